// File: doc/BRIEF.md
# Encoder Velocity Measurement Timer

This block measures how fast an encoder turns by counting encoder clock events over a fixed window of time. A down-counting period timer is loaded from a programmable reload value given in clock ticks. While it runs, every encoder clock event raises a live pulse count. When the timer has counted down through zero, the window closes. In that same clock edge the pulse count is stored in a capture register, the count starts again and the timer reloads on its own. The timer runs without pause from reset onward.

At each window close the block emits a one-cycle timer event. It also compares the captured count against a programmable threshold and emits a one-cycle low-velocity event when the capture is below it. A velocity-reset command throws away the window in progress: it clears the live count and restarts the timer from the reload value. Software reads the live timer, the live count and the capture, and turns the capture into revolutions per minute.

The encoder clock input is a single-cycle event already synchronised to `clk`. `rst_n` is asserted asynchronously and must be released synchronously to `clk`.

Top module: `enc_vel_meter`

## Requirements
- R1: While `rst_n` is low, and until the first clock edge after its release, `timer_val`, `vel_count`, `vel_capture`, `tmr_evt` and `low_vel_evt` are all zero.
- R2: The first edge after reset release loads `timer_val` from `reload_val`. From then on the timer drops by one per cycle. The edge at which it is zero reloads it, so a window lasts `reload_val`+1 cycles. `tmr_evt` is high for exactly the one cycle after that edge, and in that cycle `timer_val` equals the value just loaded.
- R3: During a window, `vel_count` rises by one on each edge at which `enc_pulse` is high and saturates at 2^CNT_W-1.
- R4: At the window-closing edge, `vel_capture` takes the value `vel_count` held before that edge; the encoder pulse present at that edge is not included. `vel_count` restarts at 1 if `enc_pulse` is high at that edge and at 0 otherwise.
- R5: `low_vel_evt` is high only together with `tmr_evt`, and then exactly when the new `vel_capture` is less than `vel_cmp` as an unsigned number, with `vel_cmp` sampled at the closing edge. An equal value gives no event.
- R6: An edge with `vel_reset` high loads the timer from `reload_val` and clears `vel_count` to 0, even if `enc_pulse` is high. It leaves `vel_capture` unchanged and produces no `tmr_evt` or `low_vel_evt`, even when the timer is zero at that edge.
- R7: A change of `reload_val` in the middle of a window does not shorten or lengthen that window. It applies at the next load.
- R8: `vel_capture` changes only in a cycle where `tmr_evt` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enc_pulse | input | 1 | One-cycle encoder clock event |
| vel_reset | input | 1 | Discard current window: clear count, reload timer |
| reload_val | input | TIMER_W | Window length minus one, in clock ticks |
| vel_cmp | input | CNT_W | Low-velocity threshold |
| timer_val | output | TIMER_W | Live period timer |
| vel_count | output | CNT_W | Live encoder pulse count of the current window |
| vel_capture | output | CNT_W | Pulse count of the last completed window |
| tmr_evt | output | 1 | One-cycle pulse after each window close |
| low_vel_evt | output | 1 | One-cycle pulse when the capture is below the threshold |

## Verification
The hardest cases to reach from the ports are those where two things happen at one exact edge. One is a velocity reset at the very edge where the timer is zero. Another is an encoder pulse at the closing edge that must go to the next window and not the one being captured. The stimulus locks onto each timer event and then counts edges exactly from there. This lets it put a pulse or a reset on a chosen edge of the window. A short counter width in the bench makes saturation reachable within a single 21-cycle window.

// File: rtl/enc_vel_pkg.sv
package enc_vel_pkg;

  // What the period timer does at the coming edge; the counter and the
  // capture stage follow the same decision.
  typedef enum logic [1:0] {
    STEP_RUN  = 2'd0,  // window continues
    STEP_WRAP = 2'd1,  // window closes: capture, restart, reload
    STEP_LOAD = 2'd2   // first load or velocity reset: no capture
  } vel_step_e;

endpackage

// File: rtl/vel_period_timer.sv
module vel_period_timer
  import enc_vel_pkg::*;
#(
  parameter int TIMER_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] reload_i,
  input  logic               restart_i,
  output logic [TIMER_W-1:0] timer_o,
  output vel_step_e          step_o
);

  localparam logic [TIMER_W-1:0] ONE = {{(TIMER_W-1){1'b0}}, 1'b1};

  logic               primed_q;
  logic               primed_d;
  logic [TIMER_W-1:0] timer_q;
  logic [TIMER_W-1:0] timer_d;
  vel_step_e          step;

  always_comb begin
    if (!primed_q || restart_i) begin
      step = STEP_LOAD;
    end else if (timer_q == '0) begin
      step = STEP_WRAP;
    end else begin
      step = STEP_RUN;
    end
  end

  always_comb begin
    primed_d = 1'b1;
    if (step == STEP_RUN) begin
      timer_d = timer_q - ONE;
    end else begin
      timer_d = reload_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      timer_q  <= '0;
    end else begin
      primed_q <= primed_d;
      timer_q  <= timer_d;
    end
  end

  assign timer_o = timer_q;
  assign step_o  = step;

  AST_TMR_ZERO_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && timer_q == '0) |=> (timer_q == $past(reload_i))); // R2

  AST_TMR_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |=> (primed_q && timer_q == $past(reload_i))); // R2

endmodule

// File: rtl/vel_pulse_counter.sv
module vel_pulse_counter
  import enc_vel_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vel_step_e        step_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = 1'b0;
    count_d  = count_q;
    case (step_i)
      STEP_LOAD: begin
        count_en = 1'b1;
        count_d  = '0;
      end
      STEP_WRAP: begin
        count_en = 1'b1;
        count_d  = pulse_i ? CNT_ONE : '0;
      end
      default: begin
        count_en = pulse_i && (count_q != CNT_MAX);
        count_d  = count_q + CNT_ONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CNT_MAX && step_i == STEP_RUN) |=> (count_q == CNT_MAX)); // R3

  AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == STEP_RUN) |=> (count_q >= $past(count_q))); // R3

endmodule

// File: rtl/vel_capture_cmp.sv
module vel_capture_cmp
  import enc_vel_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vel_step_e        step_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] capture_o,
  output logic             tmr_evt_o,
  output logic             low_evt_o
);

  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] cap_d;
  logic             cap_en;
  logic             tmr_q;
  logic             tmr_d;
  logic             low_q;
  logic             low_d;

  always_comb begin
    cap_en = (step_i == STEP_WRAP);
    cap_d  = count_i;
    tmr_d  = cap_en;
    low_d  = cap_en && (count_i < cmp_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_en) begin
      cap_q <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= 1'b0;
      low_q <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      low_q <= low_d;
    end
  end

  assign capture_o = cap_q;
  assign tmr_evt_o = tmr_q;
  assign low_evt_o = low_q;

  AST_LOW_NEEDS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
    low_q |-> tmr_q); // R5

  AST_LOW_VS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q |-> (low_q == (cap_q < $past(cmp_i)))); // R5

  AST_CAP_ONLY_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_q) |-> tmr_q); // R8

endmodule

// File: rtl/enc_vel_meter.sv
module enc_vel_meter
  import enc_vel_pkg::*;
#(
  parameter int TIMER_W = 32,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enc_pulse,
  input  logic               vel_reset,
  input  logic [TIMER_W-1:0] reload_val,
  input  logic [CNT_W-1:0]   vel_cmp,
  output logic [TIMER_W-1:0] timer_val,
  output logic [CNT_W-1:0]   vel_count,
  output logic [CNT_W-1:0]   vel_capture,
  output logic               tmr_evt,
  output logic               low_vel_evt
);

  vel_step_e step;

  vel_period_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload_i  (reload_val),
    .restart_i (vel_reset),
    .timer_o   (timer_val),
    .step_o    (step)
  );

  vel_pulse_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step),
    .pulse_i (enc_pulse),
    .count_o (vel_count)
  );

  vel_capture_cmp #(.CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step),
    .count_i   (vel_count),
    .cmp_i     (vel_cmp),
    .capture_o (vel_capture),
    .tmr_evt_o (tmr_evt),
    .low_evt_o (low_vel_evt)
  );

  AST_VRST_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    vel_reset |=> (!tmr_evt && !low_vel_evt)); // R6

  AST_VRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    vel_reset |=> (vel_count == '0 && timer_val == $past(reload_val))); // R6

  AST_VRST_KEEPS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    vel_reset |=> $stable(vel_capture)); // R6

  AST_WRAP_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_val == '0 && !vel_reset && step == STEP_WRAP)
      |=> (tmr_evt && vel_capture == $past(vel_count))); // R4

endmodule

// File: tb/enc_vel_meter_tb.sv
module enc_vel_meter_tb;

  localparam int TW  = 8;
  localparam int CW  = 4;
  localparam int MAX = (1 << CW) - 1;

  logic          clk;
  logic          rst_n;
  logic          enc_pulse;
  logic          vel_reset;
  logic [TW-1:0] reload_val;
  logic [CW-1:0] vel_cmp;
  logic [TW-1:0] timer_val;
  logic [CW-1:0] vel_count;
  logic [CW-1:0] vel_capture;
  logic          tmr_evt;
  logic          low_vel_evt;

  enc_vel_meter #(.TIMER_W(TW), .CNT_W(CW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_pulse   (enc_pulse),
    .vel_reset   (vel_reset),
    .reload_val  (reload_val),
    .vel_cmp     (vel_cmp),
    .timer_val   (timer_val),
    .vel_count   (vel_count),
    .vel_capture (vel_capture),
    .tmr_evt     (tmr_evt),
    .low_vel_evt (low_vel_evt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int cap;
    bit low;
    int gap;   // 0: do not check the distance to the previous event
    int tval;
  } exp_t;

  exp_t sb[$];
  int   checks   = 0;
  int   failures = 0;
  int   carry    = 0;
  int   last_cap = 0;
  int   gap      = 0;
  bit   done     = 1'b0;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per timer event.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      gap++;
      if (tmr_evt) begin
        if (sb.size() == 0) begin
          chk("R2", "unexpected tmr_evt", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk("R4", "vel_capture at event", vel_capture, e.cap);
          chk("R5", "low_vel_evt at event", low_vel_evt, e.low);
          chk("R2", "timer_val at event", timer_val, e.tval);
          if (e.gap != 0) chk("R2", "window length", gap, e.gap);
        end
        gap = 0;
      end else if (low_vel_evt) begin
        chk("R5", "low_vel_evt without tmr_evt", 1, 0);
      end
    end
  end

  // Driver: one window of r+1 edges; pat[i] is enc_pulse at edge i+1.
  // Called in the cycle right after a load (event, reset or first load).
  task automatic run_period(input int r, input logic [31:0] pat,
                            input int nr, input bit gchk);
    exp_t e;
    int   sum;
    sum = carry;
    for (int i = 0; i < r; i++) sum += int'(pat[i]);
    e.cap  = (sum > MAX) ? MAX : sum;
    e.low  = (e.cap < int'(vel_cmp));
    e.gap  = gchk ? r + 1 : 0;
    e.tval = (nr >= 0) ? nr : r;
    sb.push_back(e);
    for (int i = 0; i <= r; i++) begin
      chk("R2", "live timer_val", timer_val, r - i);
      if (i == r) chk("R3", "live vel_count before close", vel_count, e.cap);
      enc_pulse = pat[i];
      if (nr >= 0 && i == 2) reload_val = TW'(nr);  // R7 mid-window change
      @(negedge clk);
    end
    enc_pulse = 1'b0;
    chk("R4", "vel_count restart value", vel_count, int'(pat[r]));
    carry    = int'(pat[r]);
    last_cap = e.cap;
  endtask

  // k edges with pulses on the first two, then one edge with vel_reset.
  task automatic do_vreset(input int r, input int k);
    for (int i = 0; i < k; i++) begin
      enc_pulse = (i < 2);
      @(negedge clk);
    end
    vel_reset = 1'b1;
    enc_pulse = 1'b1;
    @(negedge clk);
    vel_reset = 1'b0;
    enc_pulse = 1'b0;
    chk("R6", "timer_val after vel_reset", timer_val, r);
    chk("R6", "vel_count after vel_reset", vel_count, 0);
    chk("R6", "vel_capture kept", vel_capture, last_cap);
    chk("R6", "no tmr_evt after vel_reset", tmr_evt, 0);
    carry = 0;
  endtask

  initial begin
    rst_n      = 1'b0;
    enc_pulse  = 1'b0;
    vel_reset  = 1'b0;
    reload_val = TW'(5);
    vel_cmp    = CW'(3);
    repeat (3) @(negedge clk);
    chk("R1", "timer_val in reset", timer_val, 0);
    chk("R1", "vel_count in reset", vel_count, 0);
    chk("R1", "vel_capture in reset", vel_capture, 0);
    chk("R1", "events in reset", {tmr_evt, low_vel_evt}, 0);
    rst_n = 1'b1;
    #1;
    chk("R1", "timer_val before first edge", timer_val, 0);
    @(negedge clk);
    chk("R2", "first load", timer_val, 5);

    run_period(5, 32'b000000, -1, 1'b0);          // 0 < 3: low
    run_period(5, 32'b010101, -1, 1'b1);          // 3 == 3: not low (R5)
    run_period(5, 32'b100001, -1, 1'b1);          // 1, pulse at close carries
    run_period(5, 32'b011110, -1, 1'b1);          // 1 + 4 = 5 (R4)
    run_period(5, 32'b000011, 8, 1'b1);           // R7: reload 8 mid-window
    run_period(8, 32'b011111111, -1, 1'b1);       // 8 pulses
    run_period(8, 32'b100000000, 20, 1'b1);       // 0, carry 1
    run_period(20, 32'h1FFFFF, 5, 1'b1);          // R3 saturation at 15

    do_vreset(5, 3);                              // R6 mid-window
    run_period(5, 32'b000111, -1, 1'b0);
    do_vreset(5, 5);                              // R6 at timer zero
    run_period(5, 32'b000000, -1, 1'b0);

    vel_cmp = CW'(0);
    run_period(5, 32'b000000, -1, 1'b1);          // R5: 0 < 0 false
    vel_cmp = CW'(15);
    run_period(5, 32'b011111, -1, 1'b1);          // R5: 5 < 15

    @(posedge clk);
    chk("R2", "pending expected events", sb.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule